// File: doc/BRIEF.md
# Bit-Serial Memory Host Sequencer

This block sits on the host side of a memory that talks over a single data line. Each bit moves in one ordinary bus cycle. A write cycle drops chip-enable and write-enable. A read cycle drops chip-enable and output-enable. The sequencer takes byte-level commands and turns each one into the right series of single-bit cycles, including the framing cycles that the memory uses to mark the start and end of an operation.

There are three commands:
- **Read.** Fetches a run of consecutive bytes starting at a 16-bit address. Each byte is handed back with a one-clock valid pulse.
- **Page write.** Pulls up to 32 bytes from a first-word-fall-through source and then issues the trigger that starts the nonvolatile write. The bytes must stay inside one 32-byte page.
- **Poll.** Repeats read cycles until the memory reports that its write has finished.

The low time and the high recovery time of every bus cycle are separate clock counts set by parameters. Every command ends with a one-clock `done` pulse. A rejected command also pulses `err` and produces no bus activity.

Top module: `bitserial_mem_seq`

## Requirements
- R1: Every read and write command begins with three bus cycles: a read, a write of 0, and a read.
- R2: The 16-bit address follows the opening triple as 16 write cycles, most significant bit first, with no read cycle among them.
- R3: A read of N bytes performs 8 read cycles per byte and assembles each byte MSB first. It presents each byte on `rd_data` with a one-clock `rd_valid` pulse. The bytes come in order. After the last byte comes one write cycle of 1, and then `done`.
- R4: A page write of N bytes pops one byte per `wd_take` pulse; `wd_data` must hold the head byte in the clock where `wd_take` is high. It sends each byte as 8 write cycles, MSB first. It then issues a read, a write of 1 and a read, and after that `done`.
- R5: The following are answered with `done` and `err` in the clock after acceptance, with no bus cycle:
  - a read with length 0;
  - a write with length 0, or with length greater than 32;
  - a write whose address low five bits plus length exceed 32;
  - command code 3.
- R6: A poll issues read cycles only, and repeats them until a read cycle samples 1 on the data line. `done` follows that cycle.
- R7: Write-enable and output-enable are never low together. Either strobe is low only while chip-enable is low, and exactly one of them is low whenever chip-enable is low.
- R8: In a write cycle the data bit is driven while the strobes are low and is still driven, unchanged, in the first clock after they rise.
- R9: The data line driver is off while output-enable is low and in the clock before output-enable falls.
- R10: Within a command, every bus cycle keeps chip-enable low for `LO_CYC` clocks, and consecutive cycles are separated by `HI_CYC` clocks of chip-enable high.
- R11: After reset and whenever `busy` is low, all strobes are high and the data driver is off. `busy` is high from the clock after a command is accepted until its `done`. Command codes are 0 read, 1 write, 2 poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Command strobe, taken when `busy` is low |
| req_cmd | input | 2 | 0 read, 1 write, 2 poll |
| req_addr | input | 16 | Start address |
| req_len | input | LEN_W | Byte count |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | One-clock rejection pulse, together with `done` |
| wd_take | output | 1 | Pop of the write data source |
| wd_data | input | 8 | Head byte of the write data source |
| rd_data | output | 8 | Byte returned by a read |
| rd_valid | output | 1 | One-clock qualifier for `rd_data` |
| mem_ce_n | output | 1 | Chip-enable, active low |
| mem_oe_n | output | 1 | Output-enable, active low |
| mem_we_n | output | 1 | Write-enable, active low |
| mem_dq_o | output | 1 | Data bit toward the memory |
| mem_dq_oe | output | 1 | Driver enable for the data bit |
| mem_dq_i | input | 1 | Data bit from the memory |

## Verification
The assertions check the electrical-order rules on every clock:
- the strobe exclusion;
- the data hold after a write strobe rises;
- the driver being off around output-enable;
- quiet outputs while idle.

Only the bench's scenarios can show the content of the cycle stream, and it checks each cycle's kind and bit against a list it builds itself. That content covers the framing triples, the address and byte order, the page-boundary rejection rule, the polling exit and the exact strobe widths. It is checked for reads at several addresses and lengths, for page writes at several offsets, and for polls with different numbers of busy readings.

// File: rtl/bitserial_mem_seq.sv
module bitserial_mem_seq #(
  parameter int LO_CYC     = 3,
  parameter int HI_CYC     = 3,
  parameter int LEN_W      = 6,
  parameter int PAGE_BYTES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_cmd,
  input  logic [15:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             wd_take,
  input  logic [7:0]       wd_data,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             mem_ce_n,
  output logic             mem_oe_n,
  output logic             mem_we_n,
  output logic             mem_dq_o,
  output logic             mem_dq_oe,
  input  logic             mem_dq_i
);
  localparam int TMAX = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int PW   = $clog2(PAGE_BYTES);

  typedef enum logic [3:0] {
    S_IDLE, S_P1, S_P0, S_P2, S_ADR, S_RD, S_REND,
    S_WR, S_T1, S_T0, S_T2, S_POLL
  } st_t;

  st_t             st;
  logic            ph;
  logic [TW-1:0]   tmr;
  logic [3:0]      bitc;
  logic [LEN_W-1:0] left;
  logic [15:0]     sh;
  logic [7:0]      wb, rb;
  logic            pbit, rdop;
  logic            is_wr, bitv, bad_wr;

  wire active = (st != S_IDLE);
  wire lo_end = active && !ph && (tmr == TW'(LO_CYC - 1));
  wire step   = active &&  ph && (tmr == TW'(HI_CYC - 1));

  always_comb begin
    is_wr = 1'b0;
    bitv  = 1'b0;
    case (st)
      S_P0:   is_wr = 1'b1;
      S_ADR:  begin is_wr = 1'b1; bitv = sh[15]; end
      S_REND: begin is_wr = 1'b1; bitv = 1'b1;   end
      S_WR:   begin is_wr = 1'b1; bitv = wb[7];  end
      S_T0:   begin is_wr = 1'b1; bitv = 1'b1;   end
      default: ;
    endcase
  end

  always_comb
    bad_wr = (req_len == '0) ||
             (int'(req_addr[PW-1:0]) + int'(req_len) > PAGE_BYTES);

  assign wd_take = step && ((st == S_ADR && bitc == 4'd15 && !rdop) ||
                            (st == S_WR  && bitc == 4'd7  && left != LEN_W'(1)));

  assign busy      = active;
  assign mem_ce_n  = !(active && !ph);
  assign mem_we_n  = !(active && !ph &&  is_wr);
  assign mem_oe_n  = !(active && !ph && !is_wr);
  assign mem_dq_oe = active && is_wr && (!ph || tmr == '0);
  assign mem_dq_o  = mem_dq_oe & bitv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= 1'b0; tmr <= '0; bitc <= '0; left <= '0;
      sh <= '0; wb <= '0; rb <= '0; pbit <= 1'b0; rdop <= 1'b0;
      done <= 1'b0; err <= 1'b0; rd_data <= '0; rd_valid <= 1'b0;
    end else begin
      done <= 1'b0;
      err <= 1'b0;
      rd_valid <= 1'b0;
      if (st == S_IDLE) begin
        ph <= 1'b0;
        tmr <= '0;
        bitc <= '0;
        if (req_valid) begin
          sh <= req_addr;
          left <= req_len;
          case (req_cmd)
            2'd0: if (req_len == '0) begin done <= 1'b1; err <= 1'b1; end
                  else begin st <= S_P1; rdop <= 1'b1; end
            2'd1: if (bad_wr) begin done <= 1'b1; err <= 1'b1; end
                  else begin st <= S_P1; rdop <= 1'b0; end
            2'd2: st <= S_POLL;
            default: begin done <= 1'b1; err <= 1'b1; end
          endcase
        end
      end else if (!ph) begin
        if (lo_end) begin
          ph <= 1'b1;
          tmr <= '0;
          if (!is_wr) begin
            pbit <= mem_dq_i;
            rb <= {rb[6:0], mem_dq_i};
          end
        end else tmr <= tmr + 1'b1;
      end else if (!step) begin
        tmr <= tmr + 1'b1;
      end else begin
        ph <= 1'b0;
        tmr <= '0;
        case (st)
          S_P1: st <= S_P0;
          S_P0: st <= S_P2;
          S_P2: begin st <= S_ADR; bitc <= '0; end
          S_ADR: begin
            sh <= {sh[14:0], 1'b0};
            bitc <= bitc + 1'b1;
            if (bitc == 4'd15) begin
              bitc <= '0;
              if (rdop) st <= S_RD;
              else begin st <= S_WR; wb <= wd_data; end
            end
          end
          S_RD: begin
            bitc <= bitc + 1'b1;
            if (bitc == 4'd7) begin
              bitc <= '0;
              rd_data <= rb;
              rd_valid <= 1'b1;
              left <= left - 1'b1;
              if (left == LEN_W'(1)) st <= S_REND;
            end
          end
          S_REND: begin st <= S_IDLE; done <= 1'b1; end
          S_WR: begin
            wb <= {wb[6:0], 1'b0};
            bitc <= bitc + 1'b1;
            if (bitc == 4'd7) begin
              bitc <= '0;
              left <= left - 1'b1;
              if (left == LEN_W'(1)) st <= S_T1;
              else wb <= wd_data;
            end
          end
          S_T1: st <= S_T0;
          S_T0: st <= S_T2;
          S_T2: begin st <= S_IDLE; done <= 1'b1; end
          S_POLL: if (pbit) begin st <= S_IDLE; done <= 1'b1; end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/bitserial_mem_seq_chk.sv
module bitserial_mem_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic err,
  input logic mem_ce_n,
  input logic mem_oe_n,
  input logic mem_we_n,
  input logic mem_dq_o,
  input logic mem_dq_oe
);
  a_r7_no_we_oe_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));
  a_r7_one_strobe_in_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> (mem_we_n != mem_oe_n));
  a_r7_strobe_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n || !mem_oe_n) |-> !mem_ce_n);
  a_r8_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_o)));
  a_r9_released_before_oe: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_dq_oe && !$past(mem_dq_oe)));
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
endmodule

bind bitserial_mem_seq bitserial_mem_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe)
);

// File: tb/tb_bitserial_mem_seq.sv
`timescale 1ns/1ps
module tb_bitserial_mem_seq;
  localparam int LO = 3, HI = 3, LW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_cmd = '0;
  logic [15:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic busy, done, err, wd_take, rd_valid;
  logic [7:0] wd_data, rd_data;
  logic mem_ce_n, mem_oe_n, mem_we_n, mem_dq_o, mem_dq_oe;
  logic mem_dq_i = 1'b1;

  always #2.5 clk = ~clk;

  bitserial_mem_seq #(.LO_CYC(LO), .HI_CYC(HI), .LEN_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_len(req_len), .busy(busy), .done(done), .err(err),
    .wd_take(wd_take), .wd_data(wd_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i));

  int n_chk = 0, n_fail = 0;
  bit exp_wr[0:511];
  bit exp_bit[0:511];
  bit ret_bit[0:511];
  string exp_tag[0:511];
  int n_exp = 0, k = 0, lowcnt = 0, hicnt = 0, rd_idx = 0, n_rd_exp = 0, wptr = 0;
  logic [7:0] exp_rd[0:63];
  logic [7:0] wbuf[0:63];
  bit cur_wr = 0, prev_ce = 1, done_seen = 0, err_seen = 0;

  assign wd_data = wbuf[wptr[5:0]];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] memval(input logic [15:0] a);
    return a[7:0] * 8'd37 + a[15:8] + 8'd11;
  endfunction

  task automatic add(input bit w, input bit b, input bit r, input string t);
    exp_wr[n_exp] = w; exp_bit[n_exp] = b; ret_bit[n_exp] = r; exp_tag[n_exp] = t;
    n_exp++;
  endtask

  task automatic add_head(input logic [15:0] a);
    add(0, 0, 1, "R1"); add(1, 0, 0, "R1"); add(0, 0, 1, "R1");
    for (int i = 15; i >= 0; i--) add(1, a[i], 0, "R2");
  endtask

  always @(posedge clk) if (wd_take) wptr <= wptr + 1;

  always @(negedge clk) if (rst_n) begin
    if (!mem_we_n && !mem_oe_n) chk(0, "R7", 1, 0);
    if (prev_ce && !mem_ce_n) begin
      cur_wr = !mem_we_n;
      lowcnt = 1;
      if (k > 0) chk(hicnt == HI, "R10", hicnt, HI);
      chk(mem_we_n != mem_oe_n, "R7", mem_we_n, !mem_oe_n);
      if (!cur_wr) begin
        chk(!mem_dq_oe, "R9", mem_dq_oe, 0);
        mem_dq_i = (k < n_exp) ? ret_bit[k] : 1'b1;
      end
    end else if (!mem_ce_n) begin
      lowcnt++;
    end else if (!prev_ce && mem_ce_n) begin
      chk(lowcnt == LO, "R10", lowcnt, LO);
      if (k < n_exp) begin
        chk(cur_wr == exp_wr[k], exp_tag[k], cur_wr, exp_wr[k]);
        if (cur_wr) begin
          chk(mem_dq_oe, "R8", mem_dq_oe, 1);
          chk(mem_dq_o == exp_bit[k], exp_tag[k], mem_dq_o, exp_bit[k]);
        end
      end else chk(0, "R1", k, n_exp);
      k++;
      hicnt = 1;
    end else hicnt++;
    prev_ce = mem_ce_n;
    if (rd_valid) begin
      chk(rd_idx < n_rd_exp && rd_data == exp_rd[rd_idx[5:0]], "R3", rd_data, exp_rd[rd_idx[5:0]]);
      rd_idx++;
    end
    if (done) begin done_seen = 1; err_seen = err; end
  end

  task automatic run(input logic [1:0] cmd, input logic [15:0] a, input int len, input bit exp_err);
    k = 0; rd_idx = 0; done_seen = 0; err_seen = 0;
    @(negedge clk);
    wptr = 0;
    req_valid = 1; req_cmd = cmd; req_addr = a; req_len = LW'(len);
    @(negedge clk);
    req_valid = 0;
    chk(busy == !exp_err, "R11", busy, !exp_err);
    for (int t = 0; t < 4000 && !done_seen; t++) @(negedge clk);
    chk(done_seen, "R11", done_seen, 1);
    chk(err_seen == exp_err, "R5", err_seen, exp_err);
    chk(k == n_exp, exp_err ? "R5" : "R1", k, n_exp);
    chk(rd_idx == n_rd_exp, "R3", rd_idx, n_rd_exp);
    if (cmd == 2'd1) chk(wptr == (exp_err ? 0 : len), "R4", wptr, exp_err ? 0 : len);
    @(negedge clk);
    chk(!busy && mem_ce_n, "R11", busy, 0);
  endtask

  task automatic do_read(input logic [15:0] a, input int len);
    n_exp = 0; n_rd_exp = 0;
    add_head(a);
    for (int j = 0; j < len; j++) begin
      logic [7:0] v;
      v = memval(a + 16'(j));
      exp_rd[j] = v;
      for (int b = 7; b >= 0; b--) add(0, 0, v[b], "R3");
    end
    add(1, 1, 0, "R3");
    n_rd_exp = len;
    run(2'd0, a, len, 0);
  endtask

  task automatic do_write(input logic [15:0] a, input int len, input bit bad);
    n_exp = 0; n_rd_exp = 0;
    for (int j = 0; j < 64; j++) wbuf[j] = a[7:0] + 8'(j * 29 + 5);
    if (!bad) begin
      add_head(a);
      for (int j = 0; j < len; j++)
        for (int b = 7; b >= 0; b--) add(1, wbuf[j][b], 0, "R4");
      add(0, 0, 1, "R4"); add(1, 1, 0, "R4"); add(0, 0, 1, "R4");
    end
    run(2'd1, a, len, bad);
  endtask

  task automatic do_poll(input int nz);
    n_exp = 0; n_rd_exp = 0;
    for (int j = 0; j < nz; j++) add(0, 0, 0, "R6");
    add(0, 0, 1, "R6");
    run(2'd2, 16'h0, 0, 0);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < 64; j++) wbuf[j] = '0;
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !busy, "R11", busy, 0);
    rst_n = 1;
    @(negedge clk);
    foreach (exp_rd[i]) exp_rd[i] = '0;
    for (int ai = 0; ai < 3; ai++)
      for (int len = 1; len <= 3; len++)
        do_read(ai == 0 ? 16'h0000 : ai == 1 ? 16'h1234 : 16'hFFFF, len);
    do_write(16'h0040, 1, 0);
    do_write(16'h0041, 31, 0);
    do_write(16'h07E0, 32, 0);
    do_write(16'h0105, 4, 0);
    do_write(16'h0041, 32, 1);
    do_write(16'h001F, 2, 1);
    do_write(16'h0000, 0, 1);
    do_write(16'h0000, 33, 1);
    n_exp = 0; n_rd_exp = 0;
    run(2'd0, 16'h0010, 0, 1);
    run(2'd3, 16'h0010, 4, 1);
    do_poll(0);
    do_poll(1);
    do_poll(3);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule